// File: doc/BRIEF.md
# Multi-Port Multi-Stream Read Buffer

This block sits between a line-fill source and a set of accelerator read ports. It stages data for many independent sequential streams. Each stream owns two line-sized slots and a byte-granular read position. On any cycle, every read port may name any stream. A port that is granted receives the chunk that starts at its position in that stream. When several ports name the same stream, each takes the next consecutive chunk. A chunk that runs off the end of one slot continues into the other slot, so the port still receives it whole in a single response.

Once a slot of a stream has been drained, the block asks for another line by presenting the stream index on the refill request interface. Lines come back on a fill interface that carries only a valid qualifier. A per-stream restart clears a stream and sets its first read position to any byte offset inside the first line that arrives afterwards. This is how a stream that does not begin on a chunk boundary is started.

Flow control works as follows:
- Read port `p` is accepted when `rd_vld[p]` and `rd_rdy[p]` are both high.
- `rd_rdy[p]` depends only on the stream's stored bytes and on the requests of lower-numbered ports. It may change in the same cycle as `rd_vld`.
- Responses are not back-pressured. They appear exactly `RSP_LATENCY` cycles after acceptance, so the consumer must always take them.
- The refill request holds until `req_rdy` is high.

Top module: `mstream_rdbuf`

## Requirements
- R1: After reset, every stream is empty: `rd_rdy` and `rsp_vld` are all low, and `req_vld` is high with `req_stream` = 0.
- R2: `req_vld` is high while some stream has fewer than two lines held plus requested. `req_stream` names the lowest such stream. A request that is not taken stays high until `req_rdy`.
- R3: A fill (`fill_vld` with `fill_stream`) stores `fill_data` as that stream's next line. A fill is sent only for a stream that has a request outstanding.
- R4: A port is ready only when its stream holds at least (k+1)·CHUNK_BYTES unread bytes. Here k is the number of lower-indexed ports that request the same stream in that cycle. Otherwise the port is not ready, and no stale data is ever returned.
- R5: Byte i of a response is the stream byte at the port's read position plus i. Byte j of a line is carried on bits 8j+7:8j, and the same ordering applies to chunks.
- R6: Ports that request the same stream in one cycle are served in ascending port order and receive consecutive chunks. The stream's position advances by CHUNK_BYTES times the number of grants.
- R7: A chunk that starts less than CHUNK_BYTES before the end of a line holds that line's tail followed by the next line's head.
- R8: `rsp_vld[p]` and `rsp_data[p]` appear exactly RSP_LATENCY cycles (default 5) after the accepting cycle, once per accepted read.
- R9: A restart (`rst_vld`, `rst_id`, `rst_off`) empties the stream. The next line filled for it is read from byte `rst_off`. In the restart cycle, ports that name that stream are not ready. A fill in the same cycle counts as the first line after the restart.
- R10: Ports that name different streams in the same cycle are served independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | NUM_PORTS | Per-port read request |
| rd_stream | input | NUM_PORTS·log2(NUM_STREAMS) | Stream index per port, port p at slice p |
| rd_rdy | output | NUM_PORTS | Per-port grant |
| rsp_vld | output | NUM_PORTS | Response valid per port |
| rsp_data | output | NUM_PORTS·CHUNK_BYTES·8 | Chunk per port, port p at slice p |
| req_vld | output | 1 | Refill request valid |
| req_rdy | input | 1 | Refill request taken |
| req_stream | output | log2(NUM_STREAMS) | Stream needing a line |
| fill_vld | input | 1 | Line fill valid |
| fill_stream | input | log2(NUM_STREAMS) | Stream the fill belongs to |
| fill_data | input | LINE_BYTES·8 | Line contents |
| rst_vld | input | 1 | Stream restart strobe |
| rst_id | input | log2(NUM_STREAMS) | Stream to restart |
| rst_off | input | log2(LINE_BYTES) | First byte offset after restart |

## Verification
The bench drives all ports onto one stream so that grants must be ranked. If the ranking is wrong, ports receive duplicated or swapped chunks, or the position advances by the wrong amount. Restarts at offsets 16 and 40 force chunks to cross a slot boundary. If the design did not wrap into the other slot, it would return bytes of the wrong line. Random traffic with a stalling request handshake drains streams to empty and exercises restarts that land alongside fills. A design that granted on insufficient data would return stale bytes. A design whose latency was off by one would raise responses in the wrong cycle.

// File: rtl/msb_pkg.sv
package msb_pkg;
  localparam int unsigned SLOTS = 2;
  typedef logic [1:0] lcnt_t;
endpackage

// File: rtl/msb_grant.sv
module msb_grant #(
  parameter int unsigned NP = 4,
  parameter int unsigned NS = 8,
  parameter int unsigned SW = 3,
  parameter int unsigned CB = 32,
  parameter int unsigned AW = 9,
  parameter int unsigned RW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    vld,
  input  logic [NP*SW-1:0] strm,
  input  logic [NS*AW-1:0] avail,
  input  logic [NS-1:0]    blk,
  output logic [NP-1:0]    rdy,
  output logic [NP*RW-1:0] rank,
  output logic [NS*RW-1:0] gcnt
);
  // Rank each port among lower ports hitting the same stream.
  always_comb begin
    rdy  = '0;
    rank = '0;
    gcnt = '0;
    for (int p = 0; p < NP; p++) begin
      int r;
      int av;
      r = 0;
      for (int q = 0; q < p; q++)
        if (vld[q] && strm[q*SW +: SW] == strm[p*SW +: SW]) r++;
      av = int'(avail[int'(strm[p*SW +: SW])*AW +: AW]);
      rdy[p] = !blk[strm[p*SW +: SW]] && (av >= (r + 1) * int'(CB));
      rank[p*RW +: RW] = RW'(r);
    end
    for (int p = 0; p < NP; p++)
      if (vld[p] && rdy[p])
        gcnt[int'(strm[p*SW +: SW])*RW +: RW] =
          gcnt[int'(strm[p*SW +: SW])*RW +: RW] + RW'(1);
  end

  for (genvar p = 1; p < NP; p++) begin : g_ord
    for (genvar q = 0; q < p; q++) begin : g_low
      // R6: a higher port never wins over a lower one on the same stream
      assert_ascending_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[p] && vld[q] && strm[p*SW +: SW] == strm[q*SW +: SW] && rdy[p]) |-> rdy[q])
        else $error("port order violated");
    end
  end
endmodule

// File: rtl/msb_chunk_sel.sv
module msb_chunk_sel #(
  parameter int unsigned LB = 128,
  parameter int unsigned CB = 32,
  parameter int unsigned OW = 7
) (
  input  logic [LB*8-1:0] head_line,
  input  logic [LB*8-1:0] next_line,
  input  logic [OW-1:0]   off,
  output logic [CB*8-1:0] chunk
);
  // Bytes past the end of the head line come from the other slot.
  always_comb begin
    chunk = '0;
    for (int i = 0; i < CB; i++) begin
      int j;
      j = int'(off) + i;
      if (j < int'(LB)) chunk[i*8 +: 8] = head_line[j*8 +: 8];
      else              chunk[i*8 +: 8] = next_line[(j-int'(LB))*8 +: 8];
    end
  end
endmodule

// File: rtl/msb_rsp_pipe.sv
module msb_rsp_pipe #(
  parameter int unsigned LAT = 5,
  parameter int unsigned W   = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);
  logic [LAT-1:0] v;
  logic [W-1:0]   d [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) v <= '0;
    else begin
      v[0] <= in_vld;
      for (int i = 1; i < LAT; i++) v[i] <= v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    d[0] <= in_data;
    for (int i = 1; i < LAT; i++) d[i] <= d[i-1];
  end

  assign out_vld  = v[LAT-1];
  assign out_data = d[LAT-1];
endmodule

// File: rtl/mstream_rdbuf.sv
module mstream_rdbuf
  import msb_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 8,
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned LINE_BYTES  = 128,
  parameter int unsigned CHUNK_BYTES = 32,
  parameter int unsigned RSP_LATENCY = 5
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [NUM_PORTS-1:0]                          rd_vld,
  input  logic [NUM_PORTS*$clog2(NUM_STREAMS)-1:0]      rd_stream,
  output logic [NUM_PORTS-1:0]                          rd_rdy,
  output logic [NUM_PORTS-1:0]                          rsp_vld,
  output logic [NUM_PORTS*CHUNK_BYTES*8-1:0]            rsp_data,
  output logic                                          req_vld,
  input  logic                                          req_rdy,
  output logic [$clog2(NUM_STREAMS)-1:0]                req_stream,
  input  logic                                          fill_vld,
  input  logic [$clog2(NUM_STREAMS)-1:0]                fill_stream,
  input  logic [LINE_BYTES*8-1:0]                       fill_data,
  input  logic                                          rst_vld,
  input  logic [$clog2(NUM_STREAMS)-1:0]                rst_id,
  input  logic [$clog2(LINE_BYTES)-1:0]                 rst_off
);
  localparam int unsigned NS = NUM_STREAMS;
  localparam int unsigned NP = NUM_PORTS;
  localparam int unsigned SW = $clog2(NUM_STREAMS);
  localparam int unsigned OW = $clog2(LINE_BYTES);
  localparam int unsigned PW = OW + 1;           // position in a two-slot ring
  localparam int unsigned AW = PW + 1;           // available byte count
  localparam int unsigned RW = $clog2(NUM_PORTS + 1);
  localparam int unsigned LW = LINE_BYTES * 8;
  localparam int unsigned CW = CHUNK_BYTES * 8;

  // Second level: two line slots per stream, plus per-stream bookkeeping.
  logic [LW-1:0] line_mem [NS][SLOTS];
  lcnt_t         cnt      [NS];
  lcnt_t         outst    [NS];
  logic [PW-1:0] rd_ptr   [NS];
  logic          wslot    [NS];

  logic [NS*AW-1:0] avail;
  logic [NS-1:0]    blk;
  logic [NP*RW-1:0] rank;
  logic [NS*RW-1:0] gcnt;
  lcnt_t            crossed  [NS];
  logic [PW-1:0]    adv      [NS];
  logic             fslot    [NS];
  logic [NS-1:0]    fill_hit;
  logic [NS-1:0]    req_hit;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      int g;
      avail[s*AW +: AW] = (cnt[s] == '0) ? '0 :
        AW'(int'(cnt[s]) * int'(LINE_BYTES) - int'(rd_ptr[s][OW-1:0]));
      blk[s]      = rst_vld && (rst_id == SW'(s));
      fill_hit[s] = fill_vld && (fill_stream == SW'(s));
      req_hit[s]  = req_vld && req_rdy && (req_stream == SW'(s));
      g           = int'(gcnt[s*RW +: RW]) * int'(CHUNK_BYTES);
      adv[s]      = PW'(g);
      crossed[s]  = lcnt_t'((int'(rd_ptr[s][OW-1:0]) + g) / int'(LINE_BYTES));
      fslot[s]    = blk[s] ? 1'b0 : wslot[s];
    end
  end

  // Lowest stream short of two lines (held plus requested).
  always_comb begin
    req_vld    = 1'b0;
    req_stream = '0;
    for (int s = NS - 1; s >= 0; s--)
      if (({1'b0, cnt[s]} + {1'b0, outst[s]}) < 3'd2) begin
        req_vld    = 1'b1;
        req_stream = SW'(s);
      end
  end

  msb_grant #(.NP(NP), .NS(NS), .SW(SW), .CB(CHUNK_BYTES), .AW(AW), .RW(RW)) u_grant (
    .clk(clk), .rst_n(rst_n), .vld(rd_vld), .strm(rd_stream),
    .avail(avail), .blk(blk), .rdy(rd_rdy), .rank(rank), .gcnt(gcnt)
  );

  // First level: each port has its own extraction path and latency pipe.
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [SW-1:0] sp;
    logic [PW-1:0] pos;
    logic          hd;
    logic [CW-1:0] chunk;
    assign sp  = rd_stream[p*SW +: SW];
    assign pos = rd_ptr[sp] + PW'(int'(rank[p*RW +: RW]) * int'(CHUNK_BYTES));
    assign hd  = pos[PW-1];

    msb_chunk_sel #(.LB(LINE_BYTES), .CB(CHUNK_BYTES), .OW(OW)) u_sel (
      .head_line(line_mem[sp][hd]), .next_line(line_mem[sp][~hd]),
      .off(pos[OW-1:0]), .chunk(chunk)
    );

    msb_rsp_pipe #(.LAT(RSP_LATENCY), .W(CW)) u_pipe (
      .clk(clk), .rst_n(rst_n), .in_vld(rd_vld[p] & rd_rdy[p]), .in_data(chunk),
      .out_vld(rsp_vld[p]), .out_data(rsp_data[p*CW +: CW])
    );

    // R4: a granted port always has at least one buffered line behind it
    assert_ready_has_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rdy[p] |-> (cnt[sp] != '0))
      else $error("ready on empty stream");
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        cnt[s]    <= '0;
        outst[s]  <= '0;
        rd_ptr[s] <= '0;
        wslot[s]  <= 1'b0;
      end
    end else begin
      for (int s = 0; s < NS; s++) begin
        outst[s] <= outst[s] + lcnt_t'(req_hit[s]) - lcnt_t'(fill_hit[s]);
        if (blk[s]) begin
          rd_ptr[s] <= {1'b0, rst_off};
          cnt[s]    <= lcnt_t'(fill_hit[s]);
          wslot[s]  <= fill_hit[s];
        end else begin
          rd_ptr[s] <= rd_ptr[s] + adv[s];
          cnt[s]    <= cnt[s] - crossed[s] + lcnt_t'(fill_hit[s]);
          if (fill_hit[s]) wslot[s] <= ~wslot[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NS; s++)
      if (fill_hit[s]) line_mem[s][fslot[s]] <= fill_data;
  end

  // R3: fills only answer outstanding requests
  assert_fill_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld |-> (outst[fill_stream] != '0))
    else $error("unrequested fill");

  for (genvar s = 0; s < NS; s++) begin : g_chk
    // R3: a stream never holds more than its two slots
    assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[s] != 2'd3)
      else $error("slot overflow");
  end

  // R2: a pending request is not withdrawn before it is taken
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_rdy) |=> req_vld)
    else $error("request dropped");
endmodule

// File: tb/mstream_rdbuf_test.sv
`timescale 1ns/1ps
module mstream_rdbuf_test;
  localparam int NS  = 8;
  localparam int NP  = 4;
  localparam int LB  = 128;
  localparam int CB  = 32;
  localparam int LAT = 5;
  localparam int SW  = $clog2(NS);
  localparam int OW  = $clog2(LB);
  localparam int CW  = CB * 8;
  localparam int LW  = LB * 8;
  localparam int NCYC = 3000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     rd_vld = '0;
  logic [NP*SW-1:0]  rd_stream = '0;
  logic [NP-1:0]     rd_rdy;
  logic [NP-1:0]     rsp_vld;
  logic [NP*CW-1:0]  rsp_data;
  logic              req_vld;
  logic              req_rdy = 1'b0;
  logic [SW-1:0]     req_stream;
  logic              fill_vld = 1'b0;
  logic [SW-1:0]     fill_stream = '0;
  logic [LW-1:0]     fill_data = '0;
  logic              rst_vld = 1'b0;
  logic [SW-1:0]     rst_id = '0;
  logic [OW-1:0]     rst_off = '0;

  always #5 clk = ~clk;

  mstream_rdbuf #(.NUM_STREAMS(NS), .NUM_PORTS(NP), .LINE_BYTES(LB),
                  .CHUNK_BYTES(CB), .RSP_LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_stream(rd_stream), .rd_rdy(rd_rdy),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .req_vld(req_vld), .req_rdy(req_rdy),
    .req_stream(req_stream), .fill_vld(fill_vld), .fill_stream(fill_stream),
    .fill_data(fill_data), .rst_vld(rst_vld), .rst_id(rst_id), .rst_off(rst_off)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Behavioural model: unread bytes per stream as a queue.
  logic [7:0]    mq [NS][$];
  int            mcnt [NS];
  int            mpil [NS];
  int            mout [NS];
  int            mdrop [NS];
  int            seqn [NS];
  int            fq [$];
  bit            pv [NP][LAT];
  logic [CW-1:0] pd [NP][LAT];
  bit            e_rdy [NP];
  logic [CW-1:0] e_chunk [NP];
  bit            e_req;
  int            e_req_s;

  task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int pst(input int p);
    return int'(rd_stream[p*SW +: SW]);
  endfunction

  task automatic model_comb();
    for (int p = 0; p < NP; p++) begin
      int st;
      int r;
      int av;
      st = pst(p);
      r = 0;
      for (int q = 0; q < p; q++) if (rd_vld[q] && pst(q) == st) r++;
      av = mcnt[st] * LB - mpil[st];
      e_rdy[p] = !(rst_vld && int'(rst_id) == st) && (av >= (r + 1) * CB);
      e_chunk[p] = '0;
      if (e_rdy[p] && rd_vld[p])
        for (int i = 0; i < CB; i++) e_chunk[p][i*8 +: 8] = mq[st][r*CB + i];
    end
    e_req = 0;
    e_req_s = 0;
    for (int s = NS - 1; s >= 0; s--)
      if (mcnt[s] + mout[s] < 2) begin e_req = 1; e_req_s = s; end
  endtask

  task automatic compare();
    for (int p = 0; p < NP; p++) begin
      chk(rd_rdy[p] == e_rdy[p], $sformatf("R4 rd_rdy[%0d]", p), CW'(rd_rdy[p]), CW'(e_rdy[p]));
      chk(rsp_vld[p] == pv[p][LAT-1], $sformatf("R8 rsp_vld[%0d]", p), CW'(rsp_vld[p]), CW'(pv[p][LAT-1]));
      if (pv[p][LAT-1])
        chk(rsp_data[p*CW +: CW] === pd[p][LAT-1], $sformatf("R5 rsp_data[%0d]", p),
            rsp_data[p*CW +: CW], pd[p][LAT-1]);
    end
    chk(req_vld == e_req, "R2 req_vld", CW'(req_vld), CW'(e_req));
    if (e_req) chk(int'(req_stream) == e_req_s, "R2 req_stream", CW'(req_stream), CW'(e_req_s));
  endtask

  task automatic model_seq();
    int g [NS];
    for (int s = 0; s < NS; s++) g[s] = 0;
    for (int p = 0; p < NP; p++) begin
      for (int k = LAT - 1; k > 0; k--) begin pv[p][k] = pv[p][k-1]; pd[p][k] = pd[p][k-1]; end
      pv[p][0] = rd_vld[p] && e_rdy[p];
      pd[p][0] = e_chunk[p];
      if (pv[p][0]) g[pst(p)]++;
    end
    // R6: position advances by one chunk per grant
    for (int s = 0; s < NS; s++) begin
      int n;
      n = g[s] * CB;
      for (int i = 0; i < n; i++) void'(mq[s].pop_front());
      mcnt[s] -= (mpil[s] + n) / LB;
      mpil[s] = (mpil[s] + n) % LB;
    end
    if (e_req && req_rdy) begin mout[e_req_s]++; fq.push_back(e_req_s); end
    // R9: restart empties the stream and sets the start offset
    if (rst_vld) begin
      int s;
      s = int'(rst_id);
      mq[s].delete();
      mcnt[s] = 0;
      mpil[s] = int'(rst_off);
      mdrop[s] = int'(rst_off);
    end
    // R3: a fill appends one line
    if (fill_vld) begin
      int s;
      s = int'(fill_stream);
      mout[s]--;
      mcnt[s]++;
      for (int i = 0; i < LB; i++) mq[s].push_back(fill_data[i*8 +: 8]);
      for (int i = 0; i < mdrop[s]; i++) void'(mq[s].pop_front());
      mdrop[s] = 0;
    end
  endtask

  task automatic drive(input int cyc);
    rd_vld = '0;
    rst_vld = 1'b0;
    req_rdy = 1'b1;
    fill_vld = 1'b0;
    if (fq.size() > 0 && $urandom_range(0, 2) != 0) begin
      int s;
      s = fq.pop_front();
      fill_vld = 1'b1;
      fill_stream = SW'(s);
      for (int j = 0; j < LB; j++) fill_data[j*8 +: 8] = 8'(s*53 + seqn[s]*29 + j*7 + 1);
      seqn[s]++;
    end
    if (cyc >= 40 && cyc < 200) begin
      // R6: every port on one stream
      req_rdy = (cyc % 3 != 0);
      rd_vld = '1;
      for (int p = 0; p < NP; p++) rd_stream[p*SW +: SW] = SW'(2);
    end else if (cyc >= 200 && cyc < 400) begin
      // R10: ports spread over distinct streams
      rd_vld = '1;
      for (int p = 0; p < NP; p++) rd_stream[p*SW +: SW] = SW'((p*3 + cyc) % NS);
    end else if (cyc >= 400 && cyc < 700) begin
      // R9 and R7: unaligned restarts make chunks straddle slots
      if (cyc == 400) begin rst_vld = 1'b1; rst_id = SW'(3); rst_off = OW'(16); end
      if (cyc == 410) begin rst_vld = 1'b1; rst_id = SW'(5); rst_off = OW'(40); end
      if (cyc >= 420) begin
        rd_vld = '1;
        for (int p = 0; p < NP; p++) rd_stream[p*SW +: SW] = SW'(p < 2 ? 3 : 5);
      end
    end else if (cyc >= 700) begin
      req_rdy = ($urandom_range(0, 3) != 0);
      for (int p = 0; p < NP; p++) begin
        rd_vld[p] = 1'($urandom_range(0, 1));
        rd_stream[p*SW +: SW] = SW'($urandom_range(0, NS - 1));
      end
      if ($urandom_range(0, 49) == 0) begin
        rst_vld = 1'b1;
        rst_id = SW'($urandom_range(0, NS - 1));
        rst_off = OW'($urandom_range(0, LB - 1));
      end
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      mcnt[s] = 0; mpil[s] = 0; mout[s] = 0; mdrop[s] = 0; seqn[s] = 0;
    end
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < LAT; k++) begin pv[p][k] = 0; pd[p][k] = '0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    chk(rd_rdy == '0 && rsp_vld == '0 && req_vld && req_stream == '0, "R1 reset state",
        CW'({rd_rdy, rsp_vld, req_vld, req_stream}), CW'({{(2*NP){1'b0}}, 1'b1, {SW{1'b0}}}));
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      if (cyc > 0) @(negedge clk);
      model_comb();
      compare();
      @(posedge clk);
      model_seq();
      #1 drive(cyc);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule